// File: doc/BRIEF.md
# Aligned PWM Generator

This block drives a single pulse-width modulated output from one counter and one compare register. The counter runs in one of two timer modes. In count-down mode it falls from the period value to zero and reloads. In count-up/down mode it climbs from zero to the period value and falls back to zero. Count-down mode gives edge-aligned pulses, at the left or the right end of each period. Count-up/down mode gives center-aligned pulses. In that mode the period value sets half of the output period.

Software-facing logic writes the period value, the compare value and the two mode selects at any time. The block copies them into its working registers only when the counter sits at zero, so a write never cuts a period short. While the enable is low the counter stays at zero, the output stays low and the copies track the inputs. The current count and a one-clock period strobe are brought out, so other logic can align sampling or further events to the waveform.

Top module: `pwm_align_gen`

## Requirements
- R1: While `en_i` is low, from the next clock edge on, `cnt_o` is 0 and both `pwm_o` and `prd_o` are 0.
- R2: With `mode_i`=0 (count-down), the counter steps LOAD, LOAD-1, …, 0 and then reloads LOAD. The period is LOAD+1 clocks, and LOAD=0 holds the counter at 0 with a period of one clock.
- R3: With `mode_i`=1 (count-up/down), the counter steps 0, 1, …, LOAD, LOAD-1, …, 1 and then returns to 0. The period is 2·LOAD clocks, or one clock when LOAD=0.
- R4: In count-down mode with `align_i`=0 (left), `pwm_o` is high while the count is below CMP. That gives exactly min(CMP, LOAD+1) high clocks per period: CMP=0 holds the output low, and CMP>LOAD holds it high.
- R5: In count-down mode with `align_i`=1 (right), `pwm_o` is the inverse of the left-aligned waveform for the same LOAD and CMP, high for LOAD+1−min(CMP, LOAD+1) clocks per period.
- R6: In count-up/down mode `align_i` is ignored. `pwm_o` is high exactly while the count is at or above CMP, on both ramps, which gives 2·(LOAD−CMP)+1 high clocks per period for 1≤CMP≤LOAD. CMP=0 gives 100 %, and CMP>LOAD holds the output low.
- R7: `prd_o` pulses for one clock each time the running counter is at 0. This marks the last clock of a count-down period and the first clock of a count-up/down period.
- R8: The values on `load_i`, `cmp_i`, `mode_i` and `align_i` are captured only on a clock edge where the counter is 0 or the block is disabled. Changes made in the middle of a period take effect at the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low forces idle |
| load_i | input | CNT_W | Period value (shadow) |
| cmp_i | input | CNT_W | Compare value (shadow) |
| mode_i | input | 1 | Timer mode: 0 count-down, 1 count-up/down |
| align_i | input | 1 | Edge alignment in count-down mode: 0 left, 1 right |
| pwm_o | output | 1 | PWM output |
| cnt_o | output | CNT_W | Current counter value |
| prd_o | output | 1 | One-clock strobe at counter zero |

## Verification
The bench sweeps every LOAD from 0 to 7 against every CMP from 0 to 9 in all three output styles. For each case it checks the counter trace, the strobe position and the high time over one whole period. This reaches the two degenerate cases, LOAD=0 and CMP above LOAD. A design that did not clamp the compare value would lose 100 % duty in left alignment or show a stray pulse in center alignment. A design with an off-by-one at the turn of the up/down ramp would give an even high count or a period of 2·LOAD±1. A mid-period write of LOAD and CMP checks that the old values finish their period. A design that loaded the new values at once would cut that period short. Dropping the enable while CMP exceeds LOAD checks that the output goes low even though the compare alone would hold it high.

// File: rtl/pwm_align_pkg.sv
package pwm_align_pkg;
  typedef enum logic {TM_DOWN = 1'b0, TM_UPDN = 1'b1} tmode_e;
  typedef enum logic {AL_LEFT = 1'b0, AL_RIGHT = 1'b1} align_e;
endpackage

// File: rtl/pwm_shadow.sv
module pwm_shadow
  import pwm_align_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             mode_i,
  input  logic             align_i,
  output logic [CNT_W-1:0] load_o,
  output logic [CNT_W-1:0] cmp_o,
  output tmode_e           mode_o,
  output align_e           align_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_o  <= '0;
      cmp_o   <= '0;
      mode_o  <= TM_DOWN;
      align_o <= AL_LEFT;
    end else if (take_i) begin
      load_o  <= load_i;
      cmp_o   <= cmp_i;
      mode_o  <= tmode_e'(mode_i);
      align_o <= align_e'(align_i);
    end
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_align_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] act_load_i,
  input  tmode_e           act_mode_i,
  input  logic [CNT_W-1:0] nxt_load_i,
  input  logic             nxt_mode_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             zero_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             up_q;
  logic             run_q;

  assign zero_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
      run_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
      run_q <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (zero_o) begin
        // period boundary: restart with the incoming settings
        up_q <= 1'b1;
        if (tmode_e'(nxt_mode_i) == TM_DOWN) cnt_q <= nxt_load_i;
        else cnt_q <= (nxt_load_i != '0) ? ONE : '0;
      end else if (act_mode_i == TM_DOWN) begin
        cnt_q <= cnt_q - ONE;
      end else if (up_q) begin
        if (cnt_q >= act_load_i) begin
          up_q  <= 1'b0;
          cnt_q <= cnt_q - ONE;
        end else begin
          cnt_q <= cnt_q + ONE;
        end
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare
  import pwm_align_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  tmode_e           mode_i,
  input  align_e           align_i,
  output logic             pwm_o
);
  logic below;
  logic lvl;

  assign below = (cnt_i < cmp_i);

  always_comb begin
    if (mode_i == TM_DOWN && align_i == AL_LEFT) lvl = below;
    else lvl = !below;  // right-aligned and center-aligned share polarity
  end

  assign pwm_o = run_i & lvl;
endmodule

// File: rtl/pwm_align_gen.sv
module pwm_align_gen
  import pwm_align_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             mode_i,
  input  logic             align_i,
  output logic             pwm_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             prd_o
);
  logic [CNT_W-1:0] act_load;
  logic [CNT_W-1:0] act_cmp;
  tmode_e           act_mode;
  align_e           act_align;
  logic             run;
  logic             at_zero;
  logic             take;

  assign take = at_zero | ~en_i;

  pwm_shadow #(.CNT_W(CNT_W)) u_shadow (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (take),
    .load_i  (load_i),
    .cmp_i   (cmp_i),
    .mode_i  (mode_i),
    .align_i (align_i),
    .load_o  (act_load),
    .cmp_o   (act_cmp),
    .mode_o  (act_mode),
    .align_o (act_align)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .act_load_i (act_load),
    .act_mode_i (act_mode),
    .nxt_load_i (load_i),
    .nxt_mode_i (mode_i),
    .cnt_o      (cnt_o),
    .run_o      (run),
    .zero_o     (at_zero)
  );

  pwm_compare #(.CNT_W(CNT_W)) u_cmp (
    .run_i   (run),
    .cnt_i   (cnt_o),
    .cmp_i   (act_cmp),
    .mode_i  (act_mode),
    .align_i (act_align),
    .pwm_o   (pwm_o)
  );

  assign prd_o = run & at_zero;
endmodule

// File: rtl/pwm_align_chk.sv
module pwm_align_chk
  import pwm_align_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [CNT_W-1:0] load_i,
  input logic             pwm_o,
  input logic [CNT_W-1:0] cnt_o,
  input logic             prd_o,
  input logic             run,
  input logic [CNT_W-1:0] act_load,
  input logic [CNT_W-1:0] act_cmp,
  input tmode_e           act_mode,
  input align_e           act_align
);
  // R1
  dis_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_o == '0 && !pwm_o && !prd_o));

  // R2
  dn_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && act_mode == TM_DOWN && cnt_o != '0) |=> cnt_o == CNT_W'($past(cnt_o) - 1'b1));

  // R3
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= act_load);

  // R4
  left_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && act_mode == TM_DOWN && act_align == AL_LEFT && act_cmp > act_load) |-> pwm_o);

  // R6
  ctr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_mode == TM_UPDN && act_cmp > act_load) |-> !pwm_o);

  // R7
  prd_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prd_o && en_i && load_i != '0) |=> !prd_o);

  // R8
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_o != '0) |=> ($stable(act_load) && $stable(act_cmp)));
endmodule

bind pwm_align_gen pwm_align_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .load_i    (load_i),
  .pwm_o     (pwm_o),
  .cnt_o     (cnt_o),
  .prd_o     (prd_o),
  .run       (run),
  .act_load  (act_load),
  .act_cmp   (act_cmp),
  .act_mode  (act_mode),
  .act_align (act_align)
);

// File: tb/sim_pwm_align_gen.sv
`timescale 1ns/1ps
module sim_pwm_align_gen;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic [W-1:0] load = '0;
  logic [W-1:0] cmp = '0;
  logic         mode = 1'b0;
  logic         align = 1'b0;
  logic         pwm;
  logic [W-1:0] cnt;
  logic         prd;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwm_align_gen #(.CNT_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .load_i(load), .cmp_i(cmp),
    .mode_i(mode), .align_i(align), .pwm_o(pwm), .cnt_o(cnt), .prd_o(prd)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int period(input int m, input int l);
    if (m == 0) return l + 1;
    return (l == 0) ? 1 : 2 * l;
  endfunction

  function automatic int exp_high(input int m, input int a, input int l, input int c);
    int mn;
    mn = (c < l + 1) ? c : l + 1;
    if (m == 0) return (a == 0) ? mn : (l + 1 - mn);
    if (l == 0) return (c == 0) ? 1 : 0;
    if (c == 0) return 2 * l;
    if (c > l) return 0;
    return 2 * (l - c) + 1;
  endfunction

  function automatic int exp_cnt(input int m, input int l, input int k);
    if (m == 0) return l + 1 - k;
    if (l == 0) return 0;
    return (k <= l) ? k : 2 * l - k;
  endfunction

  // wait at negedges for the strobe
  task automatic sync_prd();
    int g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!prd && g < 64);
  endtask

  // observe one period right after a strobe
  task automatic measure(input int m, input int l, output int hi, output int seq_bad,
                         output int prd_bad, output int last_cnt);
    int p;
    p = period(m, l);
    hi = 0; seq_bad = 0; prd_bad = 0; last_cnt = 0;
    for (int k = 1; k <= p; k++) begin
      @(negedge clk);
      if (pwm) hi++;
      if (int'(cnt) != exp_cnt(m, l, k)) begin
        seq_bad++;
        last_cnt = int'(cnt);
      end
      if (prd != (k == p)) prd_bad++;
    end
  endtask

  task automatic run_cfg(input int m, input int a, input int l, input int c);
    int hi, sb, pb, lc;
    @(negedge clk);
    en = 1'b0;
    mode = m[0]; align = a[0]; load = W'(l); cmp = W'(c);
    repeat (2) @(negedge clk);
    en = 1'b1;
    sync_prd();
    measure(m, l, hi, sb, pb, lc);
    if (m == 0) check(sb == 0, "R2 down count trace", lc, exp_cnt(m, l, 1));
    else        check(sb == 0, "R3 up/down count trace", lc, exp_cnt(m, l, 1));
    check(pb == 0, "R7 strobe position", pb, 0);
    if (m == 1)      check(hi == exp_high(m, a, l, c), "R6 center high clocks", hi, exp_high(m, a, l, c));
    else if (a == 0) check(hi == exp_high(m, a, l, c), "R4 left high clocks", hi, exp_high(m, a, l, c));
    else             check(hi == exp_high(m, a, l, c), "R5 right high clocks", hi, exp_high(m, a, l, c));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : main
    int hi, sb, pb, lc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset/idle state
    check(cnt == '0 && !pwm && !prd, "R1 idle after reset", {pwm, prd, cnt}, 0);

    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 2; a++) begin
        if (m == 1 && a == 1) continue;
        for (int l = 0; l < 8; l++)
          for (int c = 0; c < 10; c++)
            run_cfg(m, a, l, c);
      end

    // R6: align_i must not affect center mode
    run_cfg(1, 1, 5, 2);

    // R8: mid-period write applies at the next period
    @(negedge clk);
    en = 1'b0; mode = 1'b0; align = 1'b0; load = W'(5); cmp = W'(2);
    repeat (2) @(negedge clk);
    en = 1'b1;
    sync_prd();
    @(negedge clk);
    load = W'(3); cmp = W'(3);
    begin
      int h1, s1, p1, c1;
      // first sample already taken (k=1); finish remaining 5 clocks of old period
      h1 = pwm ? 1 : 0; s1 = (int'(cnt) != 5) ? 1 : 0; p1 = prd ? 1 : 0;
      for (int k = 2; k <= 6; k++) begin
        @(negedge clk);
        if (pwm) h1++;
        if (int'(cnt) != 6 - k) s1++;
        if (prd != (k == 6)) p1++;
      end
      c1 = 0;
      check(s1 == 0 && p1 == 0, "R8 old period kept", s1 + p1, c1);
      check(h1 == 2, "R8 old compare kept", h1, 2);
    end
    measure(0, 3, hi, sb, pb, lc);
    check(sb == 0 && pb == 0, "R8 new period applied", sb + pb, 0);
    check(hi == 3, "R8 new compare applied", hi, 3);

    // R1: disable while compare would force high
    @(negedge clk);
    load = W'(4); cmp = W'(9); mode = 1'b0; align = 1'b0;
    sync_prd();
    @(negedge clk);
    check(pwm == 1'b1, "R4 clamp gives full duty", pwm, 1);
    en = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(cnt == '0 && !pwm && !prd, "R1 idle when disabled", {pwm, prd, cnt}, 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule